// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block performs automatic request/clear-to-send flow control for one UART channel. On the transmit side it produces a permit signal that the transmitter consults before it begins each new character. The clear-to-send pin is synchronised and then sampled when the transmitter signals the middle of the final stop bit. That sample decides whether the following back-to-back character may start. While the transmitter is idle, the permit tracks the synchronised pin so that a halted transmitter can resume.

On the receive side the block drives the request-to-send pin from the receive FIFO fill level. It uses a halt level and a lower resume level with hysteresis between them. Both levels come from two 4-bit threshold fields in steps of four entries. When both fields are zero, the block falls back to a level derived from the selected FIFO trigger. With automatic RTS disabled, a manual control bit drives the pin directly. Both pins are active low.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After a synchronous reset, `tx_permit` is 0 while `auto_cts_en` is 1, and `rts_n_pin` is 1 while `auto_rts_en` and `manual_rts` are 0.
- R2: With `tx_busy` low and `auto_cts_en` high, `tx_permit` follows the inverse of `cts_n_pin`. The new value appears after the third rising clock edge following the pin change (two synchroniser stages plus one register).
- R3: With `tx_busy` high, `tx_permit` takes a new value only at an edge where `tx_stop_mid` is high. That value is the synchronised CTS state at that edge, so a pin change that arrives in the same cycle as the strobe is too late to affect the decision.
- R4: With `auto_cts_en` low, `tx_permit` is 1 whatever `cts_n_pin` does.
- R5: A CTS deassertion while a character is in progress (`tx_busy` high, no strobe) never withdraws `tx_permit`.
- R6: With `auto_rts_en` high, `rx_level` at or above the halt level drives `rts_n_pin` to 1 after the next rising edge, whatever `manual_rts` is.
- R7: With `auto_rts_en` high, `rx_level` at or below the resume level (and below the halt level) drives `rts_n_pin` to 0 after the next rising edge.
- R8: With `auto_rts_en` high, `rx_level` strictly between the two levels leaves `rts_n_pin` unchanged. The state after leaving the manual mode is "not halted".
- R9: When either threshold field is nonzero, the halt level is `halt_fld`×4 and the resume level is `resume_fld`×4.
- R10: When both fields are zero, the halt level is the trigger level chosen by `trig_sel` (0→8, 1→16, 2→56, 3→60), and the resume level is half of it.
- R11: With `auto_rts_en` low, `rts_n_pin` equals the inverse of `manual_rts` (writing 1 drives the pin to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_n_pin | output | 1 | Request-to-send pin, active low |
| auto_cts_en | input | 1 | Enables CTS gating of transmission |
| auto_rts_en | input | 1 | Enables level-driven RTS |
| manual_rts | input | 1 | RTS control bit used when automatic RTS is off |
| tx_busy | input | 1 | High while the transmitter is shifting a character (kept high across back-to-back characters) |
| tx_stop_mid | input | 1 | One-cycle strobe at the middle of the final stop bit |
| tx_permit | output | 1 | Transmitter may begin the next character |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| halt_fld | input | 4 | Halt threshold field, units of four entries |
| resume_fld | input | 4 | Resume threshold field, units of four entries |
| trig_sel | input | 2 | FIFO trigger selection used when both fields are zero |

## Verification
Two functions can meet in one cycle: the mid-stop-bit strobe and a change on the CTS pin. The bench raises `tx_stop_mid` in the same cycle it deasserts `cts_n_pin`. It then expects the permit to stay granted, because the synchronised sample at that edge still shows the old state. On the receive side, the manual RTS bit is held at 1 while the level crosses the halt threshold. The pin must still follow the automatic decision. Leaving the manual mode must also clear the hysteresis state.

// File: rtl/fc_pkg.sv
// Package: shared helpers for the UART flow controller.
// Assumes trigger levels of a 64-entry receive FIFO.
package fc_pkg;

    // Halt level used when both threshold fields are zero.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 56;
            default: return 60;
        endcase
    endfunction

endpackage

// File: rtl/fc_cts_sync.sv
// fc_cts_sync: multi-stage synchroniser for the active-low CTS pin.
// Assumes STAGES >= 2; resets to the inactive (high) level.
module fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic act
);
    logic [STAGES-1:0] sh;

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], pin_n};
    end

    assign act = ~sh[STAGES-1];
endmodule

// File: rtl/fc_tx_gate.sv
// fc_tx_gate: decides whether the transmitter may start its next character.
// Assumes tx_busy stays high across back-to-back characters and that
// tx_stop_mid pulses for one cycle at the middle of each final stop bit.
module fc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_act,
    input  logic tx_busy,
    input  logic tx_stop_mid,
    input  logic auto_en,
    output logic tx_permit
);
    logic permit_q;

    // Sample CTS at mid-stop while busy, track it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      permit_q <= 1'b0;
        else if (!tx_busy || tx_stop_mid) permit_q <= cts_act;
    end

    assign tx_permit = ~auto_en | permit_q;
endmodule

// File: rtl/fc_thresh_sel.sv
// fc_thresh_sel: forms the halt and resume levels from the threshold
// fields, falling back to the trigger level when both fields are zero.
// Assumes (FLD_W + STEP_LOG2) <= LVL_W.
module fc_thresh_sel
    import fc_pkg::*;
#(
    parameter int LVL_W     = 7,
    parameter int FLD_W     = 4,
    parameter int STEP_LOG2 = 2
) (
    input  logic [FLD_W-1:0] halt_fld,
    input  logic [FLD_W-1:0] resume_fld,
    input  logic [1:0]       trig_sel,
    output logic [LVL_W-1:0] halt_lvl,
    output logic [LVL_W-1:0] resume_lvl
);
    logic             use_trig;
    logic [LVL_W-1:0] trig_lvl;

    // Pick programmed or trigger-derived thresholds.
    always_comb begin
        use_trig = (halt_fld == '0) && (resume_fld == '0);
        trig_lvl = LVL_W'(trig_level(trig_sel));
        if (use_trig) begin
            halt_lvl   = trig_lvl;
            resume_lvl = trig_lvl >> 1;
        end else begin
            halt_lvl   = LVL_W'(halt_fld)   << STEP_LOG2;
            resume_lvl = LVL_W'(resume_fld) << STEP_LOG2;
        end
    end
endmodule

// File: rtl/fc_rts_ctrl.sv
// fc_rts_ctrl: hysteresis RTS driver from the receive FIFO level.
// Assumes halt_lvl > resume_lvl; if not, halting takes priority.
module fc_rts_ctrl #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             manual_rts,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output logic             rts_n
);
    logic halted_q;

    // Update the halted state with hysteresis; clear it in manual mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !auto_en)        halted_q <= 1'b0;
        else if (level >= halt_lvl)    halted_q <= 1'b1;
        else if (level <= resume_lvl)  halted_q <= 1'b0;
    end

    assign rts_n = auto_en ? halted_q : ~manual_rts;
endmodule

// File: rtl/uart_flow_ctrl.sv
// uart_flow_ctrl: automatic RTS/CTS flow control for one UART channel.
// Assumes rx_level never exceeds the FIFO depth and the CTS pin is
// asynchronous to clk.
module uart_flow_ctrl #(
    parameter int LVL_W       = 7,
    parameter int FLD_W       = 4,
    parameter int STEP_LOG2   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_n_pin,
    output logic             rts_n_pin,
    input  logic             auto_cts_en,
    input  logic             auto_rts_en,
    input  logic             manual_rts,
    input  logic             tx_busy,
    input  logic             tx_stop_mid,
    output logic             tx_permit,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [FLD_W-1:0] halt_fld,
    input  logic [FLD_W-1:0] resume_fld,
    input  logic [1:0]       trig_sel
);
    logic             cts_act;
    logic [LVL_W-1:0] halt_lvl;
    logic [LVL_W-1:0] resume_lvl;

    fc_cts_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_n(cts_n_pin), .act(cts_act)
    );

    fc_tx_gate gate_i (
        .clk(clk), .rst_n(rst_n), .cts_act(cts_act), .tx_busy(tx_busy),
        .tx_stop_mid(tx_stop_mid), .auto_en(auto_cts_en), .tx_permit(tx_permit)
    );

    fc_thresh_sel #(.LVL_W(LVL_W), .FLD_W(FLD_W), .STEP_LOG2(STEP_LOG2)) thr_i (
        .halt_fld(halt_fld), .resume_fld(resume_fld), .trig_sel(trig_sel),
        .halt_lvl(halt_lvl), .resume_lvl(resume_lvl)
    );

    fc_rts_ctrl #(.LVL_W(LVL_W)) rts_i (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .manual_rts(manual_rts),
        .level(rx_level), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
        .rts_n(rts_n_pin)
    );
endmodule

// File: rtl/fc_checker.sv
// fc_checker: properties for uart_flow_ctrl, attached by bind.
module fc_checker #(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_cts_en,
    input logic             auto_rts_en,
    input logic             manual_rts,
    input logic             tx_busy,
    input logic             tx_stop_mid,
    input logic             tx_permit,
    input logic             rts_n_pin,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] halt_lvl,
    input logic [LVL_W-1:0] resume_lvl
);
    AST_CTS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |-> tx_permit); // R4

    AST_PERMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_stop_mid && auto_cts_en) |=> (!auto_cts_en || $stable(tx_permit))); // R5

    AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_level >= halt_lvl) |=> (!auto_rts_en || rts_n_pin)); // R6

    AST_RTS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_level <= resume_lvl && rx_level < halt_lvl)
            |=> (!auto_rts_en || !rts_n_pin)); // R7

    AST_RTS_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_level > resume_lvl && rx_level < halt_lvl)
            |=> (!auto_rts_en || $stable(rts_n_pin))); // R8

    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_rts_en && manual_rts) |-> !rts_n_pin); // R11
endmodule

bind uart_flow_ctrl fc_checker #(.LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .manual_rts(manual_rts), .tx_busy(tx_busy), .tx_stop_mid(tx_stop_mid),
    .tx_permit(tx_permit), .rts_n_pin(rts_n_pin), .rx_level(rx_level),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl)
);

// File: tb/uart_flow_ctrl_tb_top.sv
// Bench: vector walk for the RTS side, directed tests for reset and CTS.
module uart_flow_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_pin = 1'b1;
    logic       rts_n_pin;
    logic       auto_cts_en = 1'b1;
    logic       auto_rts_en = 1'b0;
    logic       manual_rts = 1'b0;
    logic       tx_busy = 1'b0;
    logic       tx_stop_mid = 1'b0;
    logic       tx_permit;
    logic [6:0] rx_level = '0;
    logic [3:0] halt_fld = '0;
    logic [3:0] resume_fld = '0;
    logic [1:0] trig_sel = '0;

    int total = 0;
    int bad = 0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    uart_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n_pin), .rts_n_pin(rts_n_pin),
        .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en), .manual_rts(manual_rts),
        .tx_busy(tx_busy), .tx_stop_mid(tx_stop_mid), .tx_permit(tx_permit),
        .rx_level(rx_level), .halt_fld(halt_fld), .resume_fld(resume_fld),
        .trig_sel(trig_sel)
    );

    typedef struct packed {
        logic       auto_en;
        logic       man;
        logic [3:0] hf;
        logic [3:0] rf;
        logic [1:0] trig;
        logic [6:0] lvl;
        logic       exp_rts_n;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'd0,  4'd0, 2'd0, 7'd0,  1'b1, 4'd11}, // R11 manual 0 -> pin high
        '{1'b0, 1'b1, 4'd0,  4'd0, 2'd0, 7'd0,  1'b0, 4'd11}, // R11 manual 1 -> pin low
        '{1'b1, 1'b0, 4'd8,  4'd4, 2'd0, 7'd10, 1'b0, 4'd7},  // R7 below resume 16
        '{1'b1, 1'b0, 4'd8,  4'd4, 2'd0, 7'd31, 1'b0, 4'd8},  // R8 between, stays low
        '{1'b1, 1'b1, 4'd8,  4'd4, 2'd0, 7'd32, 1'b1, 4'd6},  // R6 at halt 32, manual ignored
        '{1'b1, 1'b0, 4'd8,  4'd4, 2'd0, 7'd20, 1'b1, 4'd8},  // R8 between, stays high
        '{1'b1, 1'b0, 4'd8,  4'd4, 2'd0, 7'd17, 1'b1, 4'd8},  // R8 just above resume
        '{1'b1, 1'b0, 4'd8,  4'd4, 2'd0, 7'd16, 1'b0, 4'd9},  // R9 resume = 4*4
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd1, 7'd15, 1'b0, 4'd10}, // R10 trig 16, between
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd1, 7'd16, 1'b1, 4'd10}, // R10 halt at trigger
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd1, 7'd9,  1'b1, 4'd10}, // R10 above half
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd1, 7'd8,  1'b0, 4'd10}, // R10 resume at half
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd3, 7'd59, 1'b0, 4'd10}, // R10 trig 60, below
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd3, 7'd64, 1'b1, 4'd10}, // R10 full FIFO halts
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd3, 7'd31, 1'b1, 4'd10}, // R10 above 30
        '{1'b1, 1'b0, 4'd0,  4'd0, 2'd3, 7'd30, 1'b0, 4'd10}, // R10 resume 30
        '{1'b1, 1'b0, 4'd15, 4'd1, 2'd0, 7'd59, 1'b0, 4'd9},  // R9 halt 60 not reached
        '{1'b1, 1'b0, 4'd15, 4'd1, 2'd0, 7'd60, 1'b1, 4'd9},  // R9 halt 60 reached
        '{1'b0, 1'b1, 4'd15, 4'd1, 2'd0, 7'd60, 1'b0, 4'd11}, // R11 manual overrides
        '{1'b1, 1'b0, 4'd15, 4'd1, 2'd0, 7'd30, 1'b0, 4'd8}   // R8 state cleared by manual mode
    };

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic run_all();
        // R1: reset state, checked during and right after synchronous reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 permit in reset", tx_permit, 1'b0);
        check("R1 rts in reset", rts_n_pin, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 permit after reset", tx_permit, 1'b0);

        // RTS vector table walk (R6..R11)
        for (int i = 0; i < NV; i++) begin
            auto_rts_en = VECS[i].auto_en;
            manual_rts  = VECS[i].man;
            halt_fld    = VECS[i].hf;
            resume_fld  = VECS[i].rf;
            trig_sel    = VECS[i].trig;
            rx_level    = VECS[i].lvl;
            @(negedge clk);
            total++;
            if (rts_n_pin !== VECS[i].exp_rts_n) begin
                bad++;
                $display("FAIL R%0d vector %0d rts_n actual=%0b expected=%0b",
                         VECS[i].req, i, rts_n_pin, VECS[i].exp_rts_n);
            end
        end

        // R2: idle tracking with three-edge latency
        cts_n_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 permit before latency", tx_permit, 1'b0);
        @(negedge clk);
        check("R2 permit after 3 edges", tx_permit, 1'b1);
        cts_n_pin = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 permit drops when idle", tx_permit, 1'b0);

        // R4: bypass with CTS inactive
        auto_cts_en = 1'b0;
        @(negedge clk);
        check("R4 bypass permit", tx_permit, 1'b1);
        auto_cts_en = 1'b1;
        cts_n_pin   = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 permit regained", tx_permit, 1'b1);

        // R5: deassert mid-character without strobe
        tx_busy   = 1'b1;
        cts_n_pin = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 permit kept mid-character", tx_permit, 1'b1);

        // R3: strobe samples the (now inactive) CTS
        tx_stop_mid = 1'b1;
        @(negedge clk);
        tx_stop_mid = 1'b0;
        check("R3 permit withdrawn at mid-stop", tx_permit, 1'b0);
        cts_n_pin = 1'b0;
        repeat (5) @(negedge clk);
        check("R3 permit held until strobe", tx_permit, 1'b0);
        tx_stop_mid = 1'b1;
        @(negedge clk);
        tx_stop_mid = 1'b0;
        check("R3 permit granted at mid-stop", tx_permit, 1'b1);

        // R3: deassert in the same cycle as the strobe is too late
        cts_n_pin   = 1'b1;
        tx_stop_mid = 1'b1;
        @(negedge clk);
        tx_stop_mid = 1'b0;
        check("R3 late deassert ignored", tx_permit, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 permit still held", tx_permit, 1'b1);
        tx_busy = 1'b0;
        @(negedge clk);
        check("R2 idle picks up inactive CTS", tx_permit, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=expired expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule